// File: doc/BRIEF.md
# Limit Register Program and Readback Engine

This block is the slave side of a two-wire serial link that stores six 11-bit threshold words, a lower and an upper one for each of three monitored channels. Each word holds ten limit bits and, as its top bit, a monitor option flag. A host writes one word in a three-byte transaction: an address byte, then a byte with a lower/upper select, the option flag and limit bits 9..8, then limit bits 7..0. The word is stored only when the host ends the transaction with a stop condition. After that the storage is busy programming for `PROG_CYCLES` clocks.

A host reads a channel in a five-byte transaction. The address byte is followed by four bytes sent by the block: a tagged header and the low eight bits of the lower word, then a tagged header and the low eight bits of the upper word. The storage is modelled as a register array that resets to zero and keeps its contents until rewritten. The SCL and SDA lines are synchronised to `clk`. The block drives SDA only low, through `sda_oe`.

Top module: `lim_engine`

## Requirements
- R1: The address byte is ACKed only if bits 7:4 equal `DEV_ID` (default 4'b1001), bit 3 is 1, and the channel field in bits 2:1 is 0, 1 or 2. Bit 0 selects a read (1) or a write (0). Any other address byte gets a NACK, and SDA then stays released until the next start.
- R2: A write stores `{option, limit[9:0]}` into the word chosen by the channel and by the select bit, and the store happens on the stop condition. The second byte holds 0000 in bits 7:4, select in bit 3 (0 = lower, 1 = upper), option in bit 2 and limit bits 9:8 in bits 1:0. The third byte holds limit bits 7:0.
- R3: A write whose second byte has any nonzero bit in positions 7:4 stores nothing.
- R4: A write that ends with fewer than two complete data bytes after the address stores nothing.
- R5: For `PROG_CYCLES` clocks after a store, every address byte gets a NACK. A transaction that was discarded starts no busy interval.
- R6: The first read byte is 1, the channel in bits 6:5, 0 in bit 4, 0 in bit 3, the lower word's option flag in bit 2 and its bits 9:8 in bits 1:0.
- R7: The second read byte is the lower limit bits 7:0. The third read byte has the layout of the first, with bit 3 = 1 and the upper word's option flag and bits. The fourth read byte is the upper limit bits 7:0.
- R8: If the host NACKs any of read bytes 1 to 3, the block releases SDA and sends nothing more until the next start.
- R9: A store changes only the addressed word. All other words keep their values.
- R10: After reset all six words read as zero and SDA is released.
- R11: A fourth byte in a write transaction gets a NACK, and the whole transaction stores nothing.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Drive SDA low when 1; release when 0 |

## Verification
A corrupted word or a wrong select decode shows up on the next read of that channel, in the header's option and MSB fields or in the following LSB byte. No other port reveals the stored words. A busy counter stuck nonzero shows up at the very next address byte as a NACK. A counter that never loads lets an address byte sent right after a store be ACKed, about 100 clocks after the stop. A transmit state machine that is one bit out of step turns every returned byte into a shifted value, and a missed abort shows up as SDA pulled low in bits that should read as ones.

// File: rtl/lim_pkg.sv
package lim_pkg;
    localparam int NCH    = 3;
    localparam int CH_W   = 2;
    localparam int DATA_W = 10;
    localparam int REG_W  = DATA_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RX   = 3'd1,
        ST_ACK  = 3'd2,
        ST_TX   = 3'd3,
        ST_HACK = 3'd4,
        ST_SKIP = 3'd5
    } eng_st_e;
endpackage

// File: rtl/lim_bus_edge.sv
module lim_bus_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    typedef struct packed {
        logic [1:0] scl_sy;
        logic [1:0] sda_sy;
        logic       scl_p;
        logic       sda_p;
    } edge_t;

    edge_t q, d;

    always_comb begin
        d        = q;
        d.scl_sy = {q.scl_sy[0], scl_i};
        d.sda_sy = {q.sda_sy[0], sda_i};
        d.scl_p  = q.scl_sy[1];
        d.sda_p  = q.sda_sy[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_s     = q.sda_sy[1];
    assign scl_rise  =  q.scl_sy[1] & ~q.scl_p;
    assign scl_fall  = ~q.scl_sy[1] &  q.scl_p;
    assign start_det =  q.scl_sy[1] & q.scl_p & q.sda_p & ~q.sda_sy[1];
    assign stop_det  =  q.scl_sy[1] & q.scl_p & ~q.sda_p & q.sda_sy[1];
endmodule

// File: rtl/lim_store.sv
module lim_store
    import lim_pkg::*;
#(
    parameter int PROG_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_upper,
    input  logic [REG_W-1:0]  wr_val,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [REG_W-1:0]  rd_lo,
    output logic [REG_W-1:0]  rd_hi,
    output logic              busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic [NCH-1:0][REG_W-1:0] lo;
        logic [NCH-1:0][REG_W-1:0] hi;
        logic [CNT_W-1:0]          cnt;
    } store_t;

    store_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_ch == CH_W'(i)) begin
                    if (wr_upper) d.hi[i] = wr_val;
                    else          d.lo[i] = wr_val;
                end
            end
            d.cnt = CNT_W'(PROG_CYCLES);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_lo = '0;
        rd_hi = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CH_W'(i)) begin
                rd_lo = q.lo[i];
                rd_hi = q.hi[i];
            end
        end
    end

    assign busy = (q.cnt != '0);
endmodule

// File: rtl/lim_engine.sv
module lim_engine
    import lim_pkg::*;
#(
    parameter logic [3:0] DEV_ID      = 4'b1001,
    parameter int         PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    typedef struct packed {
        eng_st_e           st;
        logic [7:0]        sh;
        logic [2:0]        cnt;
        logic              full;
        logic              addr;
        logic              rd;
        logic              wr_act;
        logic [CH_W-1:0]   ch;
        logic [1:0]        idx;
        logic              hack;
        logic              oe;
        logic              wsel;
        logic              wopt;
        logic [DATA_W-1:0] wdat;
        logic              wbad;
    } eng_t;

    eng_t q, d;

    logic sda_s, start_det, stop_det, scl_rise, scl_fall;
    logic wr_en, busy;
    logic [CH_W-1:0]  wr_ch;
    logic [REG_W-1:0] rd_lo, rd_hi;

    lim_bus_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    lim_store #(.PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_upper (q.wsel),
        .wr_val   ({q.wopt, q.wdat}),
        .rd_ch    (q.ch),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi),
        .busy     (busy)
    );

    function automatic logic [7:0] rd_byte(input logic [1:0] i, input logic [CH_W-1:0] c,
                                           input logic [REG_W-1:0] lo, input logic [REG_W-1:0] hi);
        case (i)
            2'd0:    return {1'b1, c, 1'b0, 1'b0, lo[10:8]};
            2'd1:    return lo[7:0];
            2'd2:    return {1'b1, c, 1'b0, 1'b1, hi[10:8]};
            default: return hi[7:0];
        endcase
    endfunction

    logic       addr_ok;
    logic [7:0] first_byte, next_byte;

    assign addr_ok    = (q.sh[7:4] == DEV_ID) && q.sh[3] &&
                        ({1'b0, q.sh[2:1]} < 3'(NCH)) && !busy;
    assign first_byte = rd_byte(2'd0, q.ch, rd_lo, rd_hi);
    assign next_byte  = rd_byte(q.idx + 2'd1, q.ch, rd_lo, rd_hi);

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (start_det) begin
            d.st     = ST_RX;
            d.cnt    = '0;
            d.full   = 1'b0;
            d.addr   = 1'b1;
            d.rd     = 1'b0;
            d.wr_act = 1'b0;
            d.idx    = '0;
            d.oe     = 1'b0;
            d.wbad   = 1'b0;
        end else if (stop_det) begin
            wr_en    = q.wr_act && !q.wbad && (q.idx == 2'd2);
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.wr_act = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) d.full = 1'b1;
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        d.cnt  = '0;
                        if (q.addr) begin
                            d.addr   = 1'b0;
                            d.ch     = q.sh[2:1];
                            d.rd     = q.sh[0];
                            d.wr_act = addr_ok && !q.sh[0];
                            d.oe     = addr_ok;
                        end else begin
                            case (q.idx)
                                2'd0: begin
                                    d.wbad = q.wbad | (q.sh[7:4] != 4'd0);
                                    d.wsel = q.sh[3];
                                    d.wopt = q.sh[2];
                                    d.wdat = {q.sh[1:0], q.wdat[7:0]};
                                    d.idx  = 2'd1;
                                    d.oe   = 1'b1;
                                end
                                2'd1: begin
                                    d.wdat = {q.wdat[9:8], q.sh};
                                    d.idx  = 2'd2;
                                    d.oe   = 1'b1;
                                end
                                default: begin
                                    d.wbad = 1'b1;
                                    d.oe   = 1'b0;
                                end
                            endcase
                        end
                        d.st = d.oe ? ST_ACK : ST_SKIP;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.st  = ST_TX;
                            d.idx = '0;
                            d.sh  = first_byte;
                            d.oe  = ~first_byte[7];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.st = ST_HACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.cnt = q.cnt + 3'd1;
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        d.hack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.hack && q.idx != 2'd3) begin
                            d.st  = ST_TX;
                            d.idx = q.idx + 2'd1;
                            d.sh  = next_byte;
                            d.cnt = '0;
                            d.oe  = ~next_byte[7];
                        end else begin
                            d.st = ST_SKIP;
                            d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_ch  = q.ch;
    assign sda_oe = q.oe;
endmodule

// File: rtl/lim_engine_chk.sv
module lim_engine_chk
    import lim_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            stop_det,
    input logic            scl_fall,
    input logic            wr_en,
    input logic            busy,
    input logic            sda_oe,
    input logic [CH_W-1:0] wr_ch
);
    assert_busy_after_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy);

    assert_no_store_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en);

    assert_sda_moves_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall));

    assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_store_channel_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_ch} < 3'(NCH)));
endmodule

bind lim_engine lim_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_det (stop_det),
    .scl_fall (scl_fall),
    .wr_en    (wr_en),
    .busy     (busy),
    .sda_oe   (sda_oe),
    .wr_ch    (wr_ch)
);

// File: tb/sim_lim_engine.sv
`timescale 1ns/1ps
module sim_lim_engine;
    localparam int         PROG = 200;
    localparam logic [3:0] DEV  = 4'b1001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;

    always #4 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    lim_engine #(.DEV_ID(DEV), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int r12_bad = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [10:0] m_lo [3];
    logic [10:0] m_hi [3];

    // R12 monitor: SDA drive may not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && scl && (sda_oe !== prev_oe)) r12_bad++;
        prev_oe = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        wt(2); sda_m = b;
        wt(4); scl = 1'b1;
        wt(3); s = sda_bus;
        wt(3); scl = 1'b0;
    endtask

    task automatic bus_start();
        wt(2); sda_m = 1'b1;
        wt(2); scl = 1'b1;
        wt(4); sda_m = 1'b0;
        wt(4); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wt(2); sda_m = 1'b0;
        wt(6); scl = 1'b1;
        wt(4); sda_m = 1'b1;
        wt(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~host_ack, s);
    endtask

    // full write; model updated on success
    task automatic do_write(input logic [1:0] ch, input logic up, input logic [10:0] v,
                            input bit settle);
        logic a0, a1, a2;
        bus_start();
        send_byte({DEV, 1'b1, ch, 1'b0}, a0);
        send_byte({4'b0000, up, v[10:8]}, a1);
        send_byte(v[7:0], a2);
        bus_stop();
        chk(a0 && a1 && a2, "R2", "write acks", {a0, a1, a2}, 3'b111);
        if (up) m_hi[ch] = v; else m_lo[ch] = v;
        if (settle) wt(PROG + 40);
    endtask

    // full read compared against the model
    task automatic do_read(input logic [1:0] ch);
        logic a;
        logic [7:0] b0, b1, b2, b3;
        bus_start();
        send_byte({DEV, 1'b1, ch, 1'b1}, a);
        chk(a, "R1", "read address ack", a, 1);
        recv_byte(1'b1, b0);
        recv_byte(1'b1, b1);
        recv_byte(1'b1, b2);
        recv_byte(1'b0, b3);
        bus_stop();
        chk(b0 == {1'b1, ch, 2'b00, m_lo[ch][10:8]}, "R6", "lower header", b0,
            {1'b1, ch, 2'b00, m_lo[ch][10:8]});
        chk(b1 == m_lo[ch][7:0], "R7", "lower lsb", b1, m_lo[ch][7:0]);
        chk(b2 == {1'b1, ch, 2'b01, m_hi[ch][10:8]}, "R7", "upper header", b2,
            {1'b1, ch, 2'b01, m_hi[ch][10:8]});
        chk(b3 == m_hi[ch][7:0], "R7", "upper lsb", b3, m_hi[ch][7:0]);
    endtask

    task automatic read_all();
        for (int c = 0; c < 3; c++) do_read(2'(c));
    endtask

    task automatic addr_nack(input logic [7:0] ab, input string what);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(ab, a);
        recv_byte(1'b0, b);
        bus_stop();
        chk(!a, "R1", what, a, 0);
        chk(b == 8'hFF, "R1", {what, " silent after nack"}, b, 8'hFF);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic a, a1, a2, a3;
        logic [7:0] b;
        for (int c = 0; c < 3; c++) begin m_lo[c] = '0; m_hi[c] = '0; end
        wt(5);
        rst_n = 1'b1;
        wt(5);
        chk(sda_oe == 1'b0, "R10", "sda released after reset", sda_oe, 0);
        read_all();  // R10 all words zero

        // R1 rejected addresses
        addr_nack({4'b0110, 1'b1, 2'd0, 1'b1}, "wrong id");
        addr_nack({DEV, 1'b0, 2'd1, 1'b1}, "e/c clear");
        addr_nack({DEV, 1'b1, 2'd3, 1'b1}, "channel 3");
        addr_nack({DEV, 1'b1, 2'd3, 1'b0}, "channel 3 write");

        // R2 R9 sweep over all words and three value patterns
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 3; c++) begin
                for (int u = 0; u < 2; u++) begin
                    logic [10:0] v;
                    v = (p == 2) ? 11'h7FF : 11'((p * 397 + c * 113 + u * 59 + 5) % 2048);
                    do_write(2'(c), u[0], v, 1'b1);
                    do_read(2'(c));
                end
            end
            read_all();
        end

        // R2 threshold example: option flags 1 (upper) and 0 (lower)
        do_write(2'd1, 1'b1, {1'b1, 10'h266}, 1'b1);
        do_write(2'd1, 1'b0, {1'b0, 10'h199}, 1'b1);
        read_all();

        // R5 busy right after a store, then released
        do_write(2'd2, 1'b0, 11'h155, 1'b0);
        bus_start();
        send_byte({DEV, 1'b1, 2'd0, 1'b1}, a);
        bus_stop();
        chk(!a, "R5", "nack while programming", a, 0);
        wt(PROG + 40);
        do_read(2'd2);

        // R4 short writes: address only, and address plus one byte
        bus_start(); send_byte({DEV, 1'b1, 2'd0, 1'b0}, a); bus_stop();
        bus_start(); send_byte({DEV, 1'b1, 2'd0, 1'b0}, a);
        send_byte({4'b0000, 1'b1, 3'b101}, a1); bus_stop();
        chk(a && a1, "R4", "short write acks", {a, a1}, 2'b11);
        do_read(2'd0);  // R4 unchanged and no busy

        // R3 reserved bits nonzero
        bus_start(); send_byte({DEV, 1'b1, 2'd1, 1'b0}, a);
        send_byte({4'b0100, 1'b0, 3'b011}, a1);
        send_byte(8'h3C, a2); bus_stop();
        do_read(2'd1);  // R3 unchanged and no busy

        // R11 fourth byte is nacked and voids the write
        bus_start(); send_byte({DEV, 1'b1, 2'd2, 1'b1 ^ 1'b1}, a);
        send_byte({4'b0000, 1'b1, 3'b110}, a1);
        send_byte(8'hA5, a2);
        send_byte(8'h5A, a3);
        bus_stop();
        chk(!a3, "R11", "fourth byte nack", a3, 0);
        do_read(2'd2);  // R11 unchanged

        // R8 host aborts after first read byte
        bus_start(); send_byte({DEV, 1'b1, 2'd1, 1'b1}, a);
        recv_byte(1'b0, b);
        chk(b == {1'b1, 2'd1, 2'b00, m_lo[1][10:8]}, "R8", "header before abort", b,
            {1'b1, 2'd1, 2'b00, m_lo[1][10:8]});
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R8", "released after abort", b, 8'hFF);
        bus_stop();
        // R8 abort after third byte
        bus_start(); send_byte({DEV, 1'b1, 2'd0, 1'b1}, a);
        recv_byte(1'b1, b); recv_byte(1'b1, b); recv_byte(1'b0, b);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R8", "released after late abort", b, 8'hFF);
        bus_stop();
        read_all();  // R9 all words intact

        chk(r12_bad == 0, "R12", "sda changes while scl high", r12_bad, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule